// File: doc/BRIEF.md
# Interrupt Controller Indirect Register Window

This block is the bus-facing register front end of an I/O interrupt controller. The bus sees only three locations. The first is a select register. The second is a 32-bit data window that reaches whichever internal register the select value names. The third is a directly written end-of-interrupt port. Through the window, software reaches a controller ID, a version word, an arbitration word that mirrors the ID, and a table of 64-bit redirection entries. Each entry is reached one 32-bit half at a time.

The block holds the redirection table itself. After every accepted entry write, it presents the new entry value on a table write port and raises a one-cycle service request, so that downstream delivery logic can re-evaluate pending lines. Two entry bits, delivery status (bit 12) and remote IRR (bit 14), belong to the delivery logic. That logic sets them through a status port, and bus writes cannot change them. A 4-byte write to the end-of-interrupt port turns into a one-cycle pulse carrying the written vector. This port exists only when the block is built as version 0x20.

Top module: `intc_regwin`

## Requirements
- R1: After reset every redirection entry reads as 0x0000_0000_0001_0000 (only the mask bit, bit 16, set), the select register and the ID read zero, and no pulse output is high.
- R2: Only address bits 7:0 are decoded: offset 0x00 is the select register (8 bits, any access size), 0x10 the data window, 0x40 the end-of-interrupt port; any other offset reads zero and ignores writes.
- R3: A data-window access whose size field is not 4 bytes reads zero and has no effect.
- R4: Window registers 0x00 (ID) and 0x02 (arbitration) both read the 4-bit ID in bits 27:24; a write to 0x00 stores only data bits 27:24; writes to 0x01 and 0x02 change nothing.
- R5: Window register 0x01 reads VERSION ORed with (NUM_PINS-1) placed at bits 23:16.
- R6: For select values of 0x10 and above the entry index is (select-0x10)>>1, an odd select reaches bits 63:32 and an even one bits 31:0; an index of NUM_PINS or more reads zero and a write to it raises no pulse.
- R7: A bus write to an entry half leaves entry bits 12 and 14 at their previous values.
- R8: When the entry resulting from a bus write has bit 15 (trigger mode, 0 = edge) clear, its bit 14 is forced to zero.
- R9: The cycle after an accepted entry write, tbl_we and svc_req are high for one cycle with tbl_idx the index and tbl_data the new entry value.
- R10: With VERSION 0x20, a 4-byte write to offset 0x40 raises eoi_valid for one cycle in the next cycle with eoi_vec equal to write data bits 7:0; other sizes, or VERSION 0x11, never raise eoi_valid.
- R11: A status-port update writes st_dstat to bit 12 and st_rirr to bit 14 of entry st_idx; it is dropped when a bus write hits the same entry in the same cycle or when st_idx is out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| st_we | input | 1 | Status update strobe from delivery logic |
| st_idx | input | IDX_W | Entry index for the status update |
| st_dstat | input | 1 | New delivery-status bit value |
| st_rirr | input | 1 | New remote-IRR bit value |
| tbl_we | output | 1 | Entry written last cycle |
| tbl_idx | output | IDX_W | Index of the written entry |
| tbl_data | output | 64 | New value of the written entry |
| svc_req | output | 1 | Service pass request pulse |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vec | output | 8 | Vector carried by the end-of-interrupt pulse |

## Verification
The bound checker watches the cycle-level properties on every clock. These are: the pulse after an in-range window write and its index (R9), the absence of a pulse after undersized or out-of-range window writes (R3, R6), edge entries never leaving with bit 14 set (R8), and the fact that each end-of-interrupt pulse traces back to a 4-byte write at offset 0x40 with the same vector (R10). The reference model in the bench covers what depends on stored contents. That means read-back of every register, retention of bits 12 and 14 across bus writes (R7), the status-port interplay (R11), and the version-dependent behaviour, which it checks on a second instance built as version 0x11.

// File: rtl/intc_regwin_pkg.sv
// Shared constants, types and the entry merge rule for the interrupt
// controller register window. Assumes 64-bit entries split in 32-bit halves.
package intc_regwin_pkg;

    // Bus offsets (low 8 address bits)
    localparam logic [7:0] OFF_SEL   = 8'h00;
    localparam logic [7:0] OFF_WIN   = 8'h10;
    localparam logic [7:0] OFF_EOI   = 8'h40;

    // Window register numbers
    localparam logic [7:0] WREG_ID   = 8'h00;
    localparam logic [7:0] WREG_VER  = 8'h01;
    localparam logic [7:0] WREG_ARB  = 8'h02;
    localparam logic [7:0] WREG_TBL  = 8'h10;

    localparam int ID_LSB      = 24;
    localparam int ID_W        = 4;
    localparam int VER_CNT_LSB = 16;
    localparam logic [2:0] FULL_WORD = 3'd4;

    // Entry bit positions decoded by the delivery logic
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;

    localparam logic [63:0] RO_MASK   = (64'd1 << B_DSTAT) | (64'd1 << B_RIRR);
    localparam logic [63:0] ENT_RESET = 64'd1 << B_MASK;

    typedef enum logic [1:0] {
        RG_SEL,
        RG_WIN,
        RG_EOI,
        RG_NONE
    } region_e;

    typedef enum logic [2:0] {
        SK_ID,
        SK_VER,
        SK_ARB,
        SK_ENT,
        SK_NONE
    } sel_kind_e;

    // New entry value after a bus write of one half: read-only bits kept,
    // remote IRR dropped when the result is edge-triggered.
    function automatic logic [63:0] merge_entry(input logic [63:0] old,
                                                input logic        hi,
                                                input logic [31:0] word);
        logic [63:0] full;
        logic [63:0] res;
        full = hi ? {word, old[31:0]} : {old[63:32], word};
        res  = (full & ~RO_MASK) | (old & RO_MASK);
        if (!res[B_TRIG]) begin
            res[B_RIRR] = 1'b0;
        end
        return res;
    endfunction

endpackage

// File: rtl/intc_regwin_decode.sv
// Bus offset decode for the register window. Purely combinational.
// Assumes ADDR_W >= 8; upper address bits are ignored.
module intc_regwin_decode
    import intc_regwin_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [2:0]        bus_size,
    output region_e           region,
    output logic              win_ok,
    output logic              sel_we,
    output logic              win_we,
    output logic              eoi_we
);

    logic [7:0] off;
    logic       full_word;

    assign off       = bus_addr[7:0];
    assign full_word = (bus_size == FULL_WORD);

    // Classify the offset into one of the three locations
    always_comb begin
        case (off)
            OFF_SEL: region = RG_SEL;
            OFF_WIN: region = RG_WIN;
            OFF_EOI: region = RG_EOI;
            default: region = RG_NONE;
        endcase
    end

    // Qualify strobes with the access size where the location demands it
    always_comb begin
        win_ok = (region == RG_WIN) && full_word;
        sel_we = bus_we && (region == RG_SEL);
        win_we = bus_we && win_ok;
        eoi_we = bus_we && (region == RG_EOI) && full_word;
    end

endmodule

// File: rtl/intc_regwin_selidx.sv
// Turns the select register value into a window target and entry index.
// Combinational; the index is only meaningful when kind is SK_ENT.
module intc_regwin_selidx
    import intc_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [7:0]       sel,
    output sel_kind_e        kind,
    output logic [IDX_W-1:0] ent_idx,
    output logic             hi_half
);

    logic [6:0] pair;

    assign pair    = 7'((sel - WREG_TBL) >> 1);
    assign ent_idx = IDX_W'(pair);
    assign hi_half = sel[0];

    // Pick the register named by the select value
    always_comb begin
        if (sel == WREG_ID) begin
            kind = SK_ID;
        end else if (sel == WREG_VER) begin
            kind = SK_VER;
        end else if (sel == WREG_ARB) begin
            kind = SK_ARB;
        end else if ((sel >= WREG_TBL) && (int'(pair) < NUM_PINS)) begin
            kind = SK_ENT;
        end else begin
            kind = SK_NONE;
        end
    end

endmodule

// File: rtl/intc_regwin_bank.sv
// Redirection entry storage. Applies bus half-writes through the merge rule
// and status updates from delivery logic; a bus write to the same entry in
// the same cycle wins over a status update. Indices >= NUM_PINS are ignored.
module intc_regwin_bank
    import intc_regwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_word,
    input  logic             st_we,
    input  logic [IDX_W-1:0] st_idx,
    input  logic             st_dstat,
    input  logic             st_rirr,
    output logic [63:0]      cur_entry,
    output logic [63:0]      wr_value
);

    logic [63:0] ent_q [NUM_PINS];

    // Select the entry addressed by the window
    always_comb begin
        cur_entry = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (wr_idx == IDX_W'(i)) begin
                cur_entry = ent_q[i];
            end
        end
    end

    // Value a bus write would leave in the addressed entry
    always_comb begin
        wr_value = merge_entry(cur_entry, wr_hi, wr_word);
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        logic hit_wr;
        logic hit_st;

        assign hit_wr = wr_en && (wr_idx == IDX_W'(g));
        assign hit_st = st_we && (st_idx == IDX_W'(g));

        // Hold one entry: reset masked, bus write, or status update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= ENT_RESET;
            end else if (hit_wr) begin
                ent_q[g] <= wr_value;
            end else if (hit_st) begin
                ent_q[g][B_DSTAT] <= st_dstat;
                ent_q[g][B_RIRR]  <= st_rirr;
            end
        end
    end

endmodule

// File: rtl/intc_regwin.sv
// Top of the interrupt controller register window. Holds the select and ID
// registers, drives read data combinationally, and registers the table
// write, service and end-of-interrupt pulses one cycle after the write.
// Assumes VERSION is 8'h11 or 8'h20; only 8'h20 builds the EOI port.
module intc_regwin
    import intc_regwin_pkg::*;
#(
    parameter int         ADDR_W   = 12,
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h20,
    localparam int        IDX_W    = $clog2(NUM_PINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              st_we,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic              st_dstat,
    input  logic              st_rirr,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic [63:0]       tbl_data,
    output logic              svc_req,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vec
);

    localparam logic [31:0] VER_WORD =
        32'(VERSION) | (32'(NUM_PINS - 1) << VER_CNT_LSB);

    region_e          region;
    logic             win_ok;
    logic             sel_we;
    logic             win_we;
    logic             eoi_we;
    sel_kind_e        kind;
    logic [IDX_W-1:0] ent_idx;
    logic             hi_half;
    logic [7:0]       sel_q;
    logic [ID_W-1:0]  id_q;
    logic             ent_wr;
    logic [63:0]      cur_entry;
    logic [63:0]      wr_value;

    intc_regwin_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_size (bus_size),
        .region   (region),
        .win_ok   (win_ok),
        .sel_we   (sel_we),
        .win_we   (win_we),
        .eoi_we   (eoi_we)
    );

    intc_regwin_selidx #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_selidx (
        .sel     (sel_q),
        .kind    (kind),
        .ent_idx (ent_idx),
        .hi_half (hi_half)
    );

    assign ent_wr = win_we && (kind == SK_ENT);

    intc_regwin_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ent_wr),
        .wr_idx    (ent_idx),
        .wr_hi     (hi_half),
        .wr_word   (bus_wdata),
        .st_we     (st_we),
        .st_idx    (st_idx),
        .st_dstat  (st_dstat),
        .st_rirr   (st_rirr),
        .cur_entry (cur_entry),
        .wr_value  (wr_value)
    );

    // Select register and ID field storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (sel_we) begin
                sel_q <= bus_wdata[7:0];
            end
            if (win_we && (kind == SK_ID)) begin
                id_q <= bus_wdata[ID_LSB +: ID_W];
            end
        end
    end

    // Read data for the currently addressed location
    always_comb begin
        bus_rdata = '0;
        if (region == RG_SEL) begin
            bus_rdata = {24'd0, sel_q};
        end else if (win_ok) begin
            case (kind)
                SK_ID, SK_ARB: bus_rdata = 32'(id_q) << ID_LSB;
                SK_VER:        bus_rdata = VER_WORD;
                SK_ENT:        bus_rdata = hi_half ? cur_entry[63:32] : cur_entry[31:0];
                default:       bus_rdata = '0;
            endcase
        end
    end

    // Table write port and service request, one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_we   <= 1'b0;
            tbl_idx  <= '0;
            tbl_data <= '0;
            svc_req  <= 1'b0;
        end else begin
            tbl_we  <= ent_wr;
            svc_req <= ent_wr;
            if (ent_wr) begin
                tbl_idx  <= ent_idx;
                tbl_data <= wr_value;
            end
        end
    end

    if (VERSION == 8'h20) begin : g_eoi
        // End-of-interrupt pulse with the written vector
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                eoi_valid <= 1'b0;
                eoi_vec   <= '0;
            end else begin
                eoi_valid <= eoi_we;
                if (eoi_we) begin
                    eoi_vec <= bus_wdata[7:0];
                end
            end
        end
    end else begin : g_no_eoi
        assign eoi_valid = 1'b0;
        assign eoi_vec   = '0;
    end

endmodule

// File: rtl/intc_regwin_chk.sv
// Protocol checker for intc_regwin, attached by bind. Relates bus writes to
// the registered pulses of the following cycle.
module intc_regwin_chk
    import intc_regwin_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h20,
    parameter int         IDX_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_off,
    input logic             bus_we,
    input logic [2:0]       bus_size,
    input logic [7:0]       bus_wbyte,
    input logic [7:0]       sel_q,
    input logic             tbl_we,
    input logic [IDX_W-1:0] tbl_idx,
    input logic [1:0]       tbl_trig_rirr,
    input logic             svc_req,
    input logic             eoi_valid,
    input logic [7:0]       eoi_vec
);

    logic [6:0] pair;
    logic       win_full_wr;
    logic       sel_in_tbl;
    logic       in_range;

    assign pair        = 7'((sel_q - WREG_TBL) >> 1);
    assign sel_in_tbl  = (sel_q >= WREG_TBL);
    assign in_range    = sel_in_tbl && (int'(pair) < NUM_PINS);
    assign win_full_wr = bus_we && (bus_off == OFF_WIN) && (bus_size == FULL_WORD);

    a_r3_short_window_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_off == OFF_WIN) && (bus_size != FULL_WORD)) |=> (!tbl_we && !svc_req));

    a_r9_entry_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full_wr && in_range) |=> (tbl_we && svc_req && (tbl_idx == IDX_W'($past(pair)))));

    a_r6_out_of_range_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (win_full_wr && sel_in_tbl && !in_range) |=> !tbl_we);

    a_r8_edge_rirr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && !tbl_trig_rirr[1]) |-> !tbl_trig_rirr[0]);

    a_r10_eoi_source: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> ($past(bus_we && (bus_off == OFF_EOI) && (bus_size == FULL_WORD))
                       && (eoi_vec == $past(bus_wbyte)) && (VERSION == 8'h20)));

    a_r9_svc_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> $past(bus_we));

endmodule

bind intc_regwin intc_regwin_chk #(
    .NUM_PINS (NUM_PINS),
    .VERSION  (VERSION),
    .IDX_W    (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_off       (bus_addr[7:0]),
    .bus_we        (bus_we),
    .bus_size      (bus_size),
    .bus_wbyte     (bus_wdata[7:0]),
    .sel_q         (sel_q),
    .tbl_we        (tbl_we),
    .tbl_idx       (tbl_idx),
    .tbl_trig_rirr (tbl_data[15:14]),
    .svc_req       (svc_req),
    .eoi_valid     (eoi_valid),
    .eoi_vec       (eoi_vec)
);

// File: tb/test_intc_regwin.sv
// Bench for intc_regwin: a behavioural reference model updated each cycle,
// a second instance built as version 0x11, and per-cycle output checks.
module test_intc_regwin;

    localparam int NP    = 24;
    localparam int IW    = 5;
    localparam int LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic        st_we = 1'b0;
    logic [IW-1:0] st_idx = '0;
    logic        st_dstat = 1'b0;
    logic        st_rirr = 1'b0;

    logic [31:0] rdata_a, rdata_b;
    logic        tbl_we_a, tbl_we_b, svc_a, svc_b, eoi_a, eoi_b;
    logic [IW-1:0] tidx_a, tidx_b;
    logic [63:0] tdat_a, tdat_b;
    logic [7:0]  evec_a, evec_b;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // Reference model state
    logic [63:0] m_ent [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic        x_tbl;
    int          x_idx;
    logic [63:0] x_dat;
    logic        x_eoi;
    logic [7:0]  x_vec;

    always #2 clk = ~clk;

    intc_regwin #(.VERSION(8'h20)) i_intc_regwin (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .st_we(st_we), .st_idx(st_idx), .st_dstat(st_dstat), .st_rirr(st_rirr),
        .tbl_we(tbl_we_a), .tbl_idx(tidx_a), .tbl_data(tdat_a), .svc_req(svc_a),
        .eoi_valid(eoi_a), .eoi_vec(evec_a));

    intc_regwin #(.VERSION(8'h11)) i_intc_regwin_v11 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .st_we(st_we), .st_idx(st_idx), .st_dstat(st_dstat), .st_rirr(st_rirr),
        .tbl_we(tbl_we_b), .tbl_idx(tidx_b), .tbl_data(tdat_b), .svc_req(svc_b),
        .eoi_valid(eoi_b), .eoi_vec(evec_b));

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] off, input logic [2:0] sz, input logic [7:0] ver);
        int k;
        if (off == 8'h00) return {24'd0, m_sel};
        if (off != 8'h10 || sz != 3'd4) return 32'd0;
        if (m_sel == 8'd0 || m_sel == 8'd2) return {4'd0, m_id, 24'd0};
        if (m_sel == 8'd1) return {8'd0, 8'(NP - 1), 8'd0, ver};
        if (m_sel < 8'h10) return 32'd0;
        k = (int'(m_sel) - 16) / 2;
        if (k >= NP) return 32'd0;
        return m_sel[0] ? m_ent[k][63:32] : m_ent[k][31:0];
    endfunction

    // One bus/status cycle: update the model, then compare pulses next cycle
    task automatic step(input logic [11:0] a, input logic we, input logic [2:0] sz, input logic [31:0] d,
                        input logic swe, input int sidx, input logic sd, input logic sr, input string tag);
        logic [7:0] off;
        int k;
        logic [63:0] o, n;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_size = sz; bus_wdata = d;
        st_we = swe; st_idx = IW'(sidx); st_dstat = sd; st_rirr = sr;
        off = a[7:0];
        x_tbl = 1'b0; x_eoi = 1'b0; x_idx = -1;
        if (we) begin
            if (off == 8'h00) begin
                m_sel = d[7:0];
            end else if (off == 8'h10 && sz == 3'd4) begin
                if (m_sel == 8'd0) begin
                    m_id = d[27:24];
                end else if (m_sel >= 8'h10) begin
                    k = (int'(m_sel) - 16) / 2;
                    if (k < NP) begin
                        o = m_ent[k];
                        n = o;
                        if (m_sel[0]) n[63:32] = d; else n[31:0] = d;
                        n[12] = o[12];
                        n[14] = o[14];
                        if (!n[15]) n[14] = 1'b0;
                        m_ent[k] = n;
                        x_tbl = 1'b1; x_idx = k; x_dat = n;
                    end
                end
            end else if (off == 8'h40 && sz == 3'd4) begin
                x_eoi = 1'b1; x_vec = d[7:0];
            end
        end
        if (swe && sidx < NP && sidx != x_idx) begin
            m_ent[sidx][12] = sd;
            m_ent[sidx][14] = sr;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tbl_we_a === x_tbl && svc_a === x_tbl, {tag, " R9 tbl_we/svc_req"}, {tbl_we_a, svc_a}, {x_tbl, x_tbl});
        if (x_tbl) begin
            chk(int'(tidx_a) == x_idx && tdat_a === x_dat, {tag, " R9 tbl_idx/tbl_data"}, tdat_a, x_dat);
        end
        chk(eoi_a === x_eoi, {tag, " R10 eoi_valid"}, 64'(eoi_a), 64'(x_eoi));
        if (x_eoi) chk(evec_a === x_vec, {tag, " R10 eoi_vec"}, 64'(evec_a), 64'(x_vec));
        chk(eoi_b === 1'b0, {tag, " R10 eoi_valid v11"}, 64'(eoi_b), 64'd0);
        bus_we = 1'b0; st_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [2:0] sz, input string tag);
        logic [31:0] ea, eb;
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0; bus_size = sz;
        #1;
        ea = model_read(a[7:0], sz, 8'h20);
        eb = model_read(a[7:0], sz, 8'h11);
        chk(rdata_a === ea, tag, 64'(rdata_a), 64'(ea));
        chk(rdata_b === eb, {tag, " v11"}, 64'(rdata_b), 64'(eb));
    endtask

    task automatic wsel(input logic [7:0] s);
        step(12'h000, 1'b1, 3'd4, {24'd0, s}, 1'b0, 0, 1'b0, 1'b0, "sel");
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > LIMIT) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, LIMIT);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h1_0000;
        m_sel = '0; m_id = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!tbl_we_a && !svc_a && !eoi_a, "R1 reset pulses low", {tbl_we_a, svc_a, eoi_a}, 0);

        // R1: reset contents
        rd(12'h000, 3'd4, "R1 select after reset");
        rd(12'h010, 3'd4, "R1 ID after reset");
        for (int i = 0; i < NP; i++) begin
            wsel(8'(16 + 2 * i));
            rd(12'h010, 3'd4, "R1 entry low after reset");
            wsel(8'(17 + 2 * i));
            rd(12'h010, 3'd4, "R1 entry high after reset");
        end

        // R2: upper address bits ignored, unmapped offsets inert
        step(12'hA00, 1'b1, 3'd1, 32'h0000_0002, 1'b0, 0, 1'b0, 1'b0, "R2 select via aliased address");
        rd(12'hF00, 3'd2, "R2 select read aliased, any size");
        step(12'h020, 1'b1, 3'd4, 32'h0000_0055, 1'b0, 0, 1'b0, 1'b0, "R2 unmapped write");
        rd(12'h020, 3'd4, "R2 unmapped read zero");
        rd(12'h000, 3'd4, "R2 select unchanged");

        // R4: ID, arbitration mirror, ignored writes
        wsel(8'h00);
        step(12'h010, 1'b1, 3'd4, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b0, "R4 ID write");
        rd(12'h010, 3'd4, "R4 ID read field only");
        wsel(8'h02);
        step(12'h010, 1'b1, 3'd4, 32'h0300_0000, 1'b0, 0, 1'b0, 1'b0, "R4 arb write ignored");
        rd(12'h010, 3'd4, "R4 arbitration mirrors ID");
        wsel(8'h01);
        step(12'h010, 1'b1, 3'd4, 32'h0000_0000, 1'b0, 0, 1'b0, 1'b0, "R4 version write ignored");
        // R5: version word, both builds
        rd(12'h010, 3'd4, "R5 version word");

        // R3: short window accesses
        wsel(8'h10);
        step(12'h010, 1'b1, 3'd2, 32'h0000_00AB, 1'b0, 0, 1'b0, 1'b0, "R3 2-byte window write");
        rd(12'h010, 3'd2, "R3 2-byte window read zero");
        rd(12'h010, 3'd4, "R3 entry unchanged");

        // R6/R9: entry halves and range limit
        step(12'h010, 1'b1, 3'd4, 32'h0000_8031, 1'b0, 0, 1'b0, 1'b0, "R6 entry 0 low write");
        rd(12'h010, 3'd4, "R6 entry 0 low read");
        wsel(8'h3F);
        step(12'h010, 1'b1, 3'd4, 32'hA500_0000, 1'b0, 0, 1'b0, 1'b0, "R6 entry 23 high write");
        rd(12'h010, 3'd4, "R6 entry 23 high read");
        wsel(8'h3E);
        rd(12'h010, 3'd4, "R6 entry 23 low untouched");
        wsel(8'h40);
        step(12'h010, 1'b1, 3'd4, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b0, "R6 index 24 write no pulse");
        rd(12'h010, 3'd4, "R6 index 24 reads zero");
        wsel(8'h0F);
        rd(12'h010, 3'd4, "R6 select below table reads zero");

        // R11/R7: status bits survive bus writes on a level entry
        step(12'h000, 1'b0, 3'd4, 0, 1'b1, 5, 1'b1, 1'b1, "R11 status set entry 5");
        wsel(8'h1A);
        rd(12'h010, 3'd4, "R11 status visible entry 5");
        step(12'h010, 1'b1, 3'd4, 32'h0000_8040, 1'b0, 0, 1'b0, 1'b0, "R7 level write keeps RO bits");
        rd(12'h010, 3'd4, "R7 RO bits kept");
        wsel(8'h1C);
        step(12'h010, 1'b1, 3'd4, 32'h0000_D041, 1'b0, 0, 1'b0, 1'b0, "R7 RO bits not settable");
        rd(12'h010, 3'd4, "R7 RO bits stay clear");
        // R11: same-cycle collision and out-of-range status
        step(12'h010, 1'b1, 3'd4, 32'h0000_8042, 1'b1, 6, 1'b1, 1'b1, "R11 collision bus wins");
        rd(12'h010, 3'd4, "R11 collision dropped status");
        step(12'h000, 1'b0, 3'd4, 0, 1'b1, 30, 1'b1, 1'b1, "R11 out-of-range status");

        // R8: edge write clears remote IRR, keeps delivery status
        step(12'h000, 1'b0, 3'd4, 0, 1'b1, 7, 1'b1, 1'b1, "R8 status set entry 7");
        wsel(8'h1E);
        step(12'h010, 1'b1, 3'd4, 32'h0000_0050, 1'b0, 0, 1'b0, 1'b0, "R8 edge write");
        rd(12'h010, 3'd4, "R8 remote IRR cleared");

        // R10: end of interrupt
        step(12'h040, 1'b1, 3'd4, 32'h0000_0150, 1'b0, 0, 1'b0, 1'b0, "R10 EOI 4-byte");
        step(12'h040, 1'b1, 3'd1, 32'h0000_0033, 1'b0, 0, 1'b0, 1'b0, "R10 EOI 1-byte ignored");
        step(12'h540, 1'b1, 3'd4, 32'h0000_00FE, 1'b0, 0, 1'b0, 1'b0, "R10 EOI aliased address");
        rd(12'h040, 3'd4, "R2 EOI offset reads zero");

        // Back-to-back mixed traffic over many entries
        for (int i = 0; i < NP; i++) begin
            wsel(8'(16 + 2 * i + (i % 2)));
            step(12'h010, 1'b1, 3'd4, 32'(i * 32'h0101_1041), 1'b1, (i + 3) % NP, 1'(i % 2), 1'b1, "R9 sweep");
            rd(12'h010, 3'd4, "R7 sweep read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule